// File: doc/BRIEF.md
# Pre-trigger circular capture buffer

The block records a window of a continuous 32-bit sample stream around a trigger event. Once armed, every valid sample goes into an on-chip ring whose length is chosen at arm time, so the newest samples keep overwriting the oldest. A trigger pulse, when enabled and accepted, marks the position of the event within the record. The block then collects the remaining post-event samples and freezes the ring. After that it plays the whole record out on a stream master, oldest sample first.

Capture and playback never overlap. While the record is being played out, incoming samples are dropped. The record holds `len` samples in total. The trigger position `pre` sets how many of them come from before the trigger. The samples presented in the cycle of an accepted trigger count as pre-trigger data. The values `len` and `pre` are sampled on the arm strobe. They must satisfy 1 <= len <= DEPTH and pre <= len.

The output follows AXI4-Stream rules. A beat transfers on a rising edge where TVALID and TREADY are both high. While TVALID is high and TREADY is low, TDATA and TLAST hold their values and TVALID stays high. TREADY may stay low for any number of cycles, and no beat is lost or repeated.

Top module: `pretrig_capture`

## Requirements
- R1: After reset, status is 0 (idle), busy and done are low, and m_tvalid is low.
- R2: An arm strobe is taken only when status is idle (0) or done (4). It moves status to armed (1) and latches cfg_len and cfg_pre. An arm strobe in any other state is ignored, and so is any later change of cfg_len or cfg_pre.
- R3: While armed or post-trigger, every valid sample is written into a ring of cfg_len entries. The played-out record is always the last len samples written, oldest first.
- R4: While trig_en is low, trig_pulse is ignored and status stays armed (1).
- R5: A trigger is accepted only if at least pre samples were written since arming, counting cycles before the trigger cycle only. Earlier trigger pulses are ignored.
- R6: After an accepted trigger, exactly len - pre further valid samples are captured and status shows post-trigger (2) meanwhile. When pre equals len, playback follows the trigger directly.
- R7: Playback emits exactly len beats, with m_tlast high on the last beat only. m_tvalid is high only in the readout state (3).
- R8: While m_tvalid is high and m_tready is low, m_tdata and m_tlast are held and m_tvalid stays high.
- R9: The status codes are idle 0, armed 1, post-trigger 2, readout 3 and done 4. busy is high in states 1 to 3, and done is high in state 4. The state becomes done right after the last beat transfers.
- R10: Samples presented during readout or done are not captured and do not alter the record being played out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Sample value |
| in_valid | input | 1 | Sample present this cycle |
| trig_pulse | input | 1 | One-cycle trigger event |
| trig_en | input | 1 | Trigger enable; when low, triggers are ignored |
| cfg_len | input | $clog2(DEPTH+1) | Record length in samples (1..DEPTH) |
| cfg_pre | input | $clog2(DEPTH+1) | Pre-trigger samples (0..cfg_len) |
| arm | input | 1 | Arm strobe |
| busy | output | 1 | Armed, post-trigger or reading out |
| done | output | 1 | Record fully played out |
| status | output | 3 | State code (see R9) |
| m_tdata | output | DATA_W | Stream data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tlast | output | 1 | Last beat of the record |

## Verification
The record is tried with a short ring that wraps several times before the trigger, a full-depth ring triggered at once with gaps in the input, a record that is all pre-trigger data, and a single-entry ring. Together these separate wrong wrap points, a wrong oldest-sample address and an off-by-one count of post-trigger samples. Trigger pulses that come too early or while disabled, and arm strobes during capture and readout, show whether each is really ignored. Random TREADY stalls against a scoreboard catch any lost, repeated or changing beat. Samples fed during playback catch capture that has not stopped.

// File: rtl/pretrig_pkg.sv
package pretrig_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_POST  = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_t;
endpackage

// File: rtl/pretrig_ram.sv
module pretrig_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // asynchronous read keeps the stream hold rule trivial under stalls
  assign rdata = mem[raddr];
endmodule

// File: rtl/pretrig_ctrl.sv
module pretrig_ctrl
  import pretrig_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LEN_W-1:0]  cfg_pre,
  input  logic              in_valid,
  input  logic              trig_pulse,
  input  logic              trig_en,
  input  logic              rd_finish,
  output cap_state_t        state,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              rd_start,
  output logic [ADDR_W-1:0] rd_start_addr,
  output logic [LEN_W-1:0]  len_q
);
  logic [LEN_W-1:0]  pre_q;
  logic [LEN_W-1:0]  fill;
  logic [LEN_W-1:0]  post_left;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] wr_ptr_inc;
  logic [ADDR_W-1:0] wr_ptr_nxt;
  logic [LEN_W-1:0]  post_need;
  logic              capturing;
  logic              trig_ok;
  logic              post_last;

  always_comb begin
    capturing  = (state == ST_ARMED) || (state == ST_POST);
    we         = capturing && in_valid;
    wr_ptr_inc = (LEN_W'(wr_ptr) == len_q - LEN_W'(1)) ? '0 : wr_ptr + ADDR_W'(1);
    wr_ptr_nxt = we ? wr_ptr_inc : wr_ptr;
    post_need  = len_q - pre_q;
    trig_ok    = (state == ST_ARMED) && trig_en && trig_pulse && (fill >= pre_q);
    post_last  = (state == ST_POST) && in_valid && (post_left == LEN_W'(1));
    rd_start   = (trig_ok && (post_need == '0)) || post_last;
    // after the final write the next write slot holds the oldest sample
    rd_start_addr = wr_ptr_nxt;
  end

  assign waddr = wr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      len_q     <= LEN_W'(1);
      pre_q     <= '0;
      fill      <= '0;
      post_left <= '0;
      wr_ptr    <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (arm) begin
            len_q  <= cfg_len;
            pre_q  <= cfg_pre;
            fill   <= '0;
            wr_ptr <= '0;
            state  <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          wr_ptr <= wr_ptr_nxt;
          if (we && (fill != '1)) fill <= fill + LEN_W'(1);
          if (trig_ok) begin
            if (post_need == '0) begin
              state <= ST_READ;
            end else begin
              post_left <= post_need;
              state     <= ST_POST;
            end
          end
        end
        ST_POST: begin
          wr_ptr <= wr_ptr_nxt;
          if (we) post_left <= post_left - LEN_W'(1);
          if (post_last) state <= ST_READ;
        end
        ST_READ: begin
          if (rd_finish) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pretrig_reader.sv
module pretrig_reader #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len_q,
  input  logic              m_tready,
  output logic [ADDR_W-1:0] raddr,
  output logic              m_tvalid,
  output logic              m_tlast,
  output logic              finish
);
  logic              active;
  logic [ADDR_W-1:0] rd_ptr;
  logic [LEN_W-1:0]  left;
  logic              fire;

  always_comb begin
    raddr    = rd_ptr;
    m_tvalid = active;
    m_tlast  = active && (left == LEN_W'(1));
    fire     = active && m_tready;
    finish   = fire && (left == LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_ptr <= '0;
      left   <= '0;
    end else if (start) begin
      active <= 1'b1;
      rd_ptr <= start_addr;
      left   <= len_q;
    end else if (fire) begin
      rd_ptr <= (LEN_W'(rd_ptr) == len_q - LEN_W'(1)) ? '0 : rd_ptr + ADDR_W'(1);
      left   <= left - LEN_W'(1);
      if (left == LEN_W'(1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
  import pretrig_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              trig_pulse,
  input  logic              trig_en,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LEN_W-1:0]  cfg_pre,
  input  logic              arm,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);
  cap_state_t        state;
  logic              wr_en;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic              rd_start;
  logic [ADDR_W-1:0] rd_start_addr;
  logic [LEN_W-1:0]  len_q;
  logic              rd_finish;

  pretrig_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .cfg_len       (cfg_len),
    .cfg_pre       (cfg_pre),
    .in_valid      (in_valid),
    .trig_pulse    (trig_pulse),
    .trig_en       (trig_en),
    .rd_finish     (rd_finish),
    .state         (state),
    .we            (wr_en),
    .waddr         (waddr),
    .rd_start      (rd_start),
    .rd_start_addr (rd_start_addr),
    .len_q         (len_q)
  );

  pretrig_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (in_data),
    .raddr (raddr),
    .rdata (m_tdata)
  );

  pretrig_reader #(.DEPTH(DEPTH)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_start),
    .start_addr (rd_start_addr),
    .len_q      (len_q),
    .m_tready   (m_tready),
    .raddr      (raddr),
    .m_tvalid   (m_tvalid),
    .m_tlast    (m_tlast),
    .finish     (rd_finish)
  );

  always_comb begin
    status = state;
    busy   = (state == ST_ARMED) || (state == ST_POST) || (state == ST_READ);
    done   = (state == ST_DONE);
  end
endmodule

// File: rtl/pretrig_capture_chk.sv
module pretrig_capture_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              trig_en,
  input logic [2:0]        status,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] m_tdata,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tlast,
  input logic              wr_en
);
  p_arm_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == 3'd2) || (status == 3'd3)) && arm |=> (status != 3'd1));

  p_trig_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd1) && !trig_en |=> (status == 3'd1));

  p_valid_only_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (status == 3'd3));

  p_stable_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> (status == 3'd4) && done);

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  p_no_capture_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !wr_en);
endmodule

bind pretrig_capture pretrig_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arm      (arm),
  .trig_en  (trig_en),
  .status   (status),
  .busy     (busy),
  .done     (done),
  .m_tdata  (m_tdata),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .m_tlast  (m_tlast),
  .wr_en    (wr_en)
);

// File: tb/pretrig_capture_test.sv
`timescale 1ns/1ps
module pretrig_capture_test;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int LEN_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic              trig_pulse = 1'b0;
  logic              trig_en = 1'b0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic [LEN_W-1:0]  cfg_pre = '0;
  logic              arm = 1'b0;
  logic              busy, done;
  logic [2:0]        status;
  logic [DATA_W-1:0] m_tdata;
  logic              m_tvalid;
  logic              m_tready = 1'b1;
  logic              m_tlast;

  always #2.5 clk = ~clk;

  pretrig_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .trig_pulse(trig_pulse), .trig_en(trig_en), .cfg_len(cfg_len),
    .cfg_pre(cfg_pre), .arm(arm), .busy(busy), .done(done), .status(status),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // scoreboard
  logic [DATA_W-1:0] exp_q[$];
  bit                last_q[$];

  // requirement-level model: 0 idle 1 armed 2 post 3 read 4 done
  int mstate = 0;
  int mlen, mpre, mcount, mpost;
  logic [DATA_W-1:0] hist[$];
  logic [DATA_W-1:0] seq = 32'hA500_0000;
  bit bp = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_finish();
    for (int k = 0; k < mlen; k++) begin
      exp_q.push_back(hist[hist.size() - mlen + k]);
      last_q.push_back(k == mlen - 1);
    end
    mstate = 3;
  endtask

  task automatic step(input bit v, input bit t, input bit en);
    bit hit;
    @(posedge clk); #1;
    arm = 1'b0;
    in_valid = v;
    in_data = seq;
    trig_pulse = t;
    trig_en = en;
    if (mstate == 1) begin
      hit = t && en && (mcount >= mpre);
      if (v) begin hist.push_back(seq); mcount++; end
      if (hit) begin
        if (mlen - mpre == 0) model_finish();
        else begin mpost = mlen - mpre; mstate = 2; end
      end
    end else if (mstate == 2) begin
      if (v) begin
        hist.push_back(seq);
        mpost--;
        if (mpost == 0) model_finish();
      end
    end
    if (v) seq = seq + 32'h0000_0101;
  endtask

  task automatic arm_cmd(input int len, input int pre);
    @(posedge clk); #1;
    in_valid = 1'b0;
    trig_pulse = 1'b0;
    cfg_len = LEN_W'(len);
    cfg_pre = LEN_W'(pre);
    arm = 1'b1;
    if (mstate == 0 || mstate == 4) begin
      mstate = 1; mlen = len; mpre = pre; mcount = 0;
      hist.delete();
    end
  endtask

  task automatic chk_status(input int exp, input string req);
    check(status == 3'(exp), req, 32'(status), 32'(exp));
  endtask

  task automatic drain();
    for (int n = 0; n < 4000 && exp_q.size() > 0; n++) step(0, 0, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    check(exp_q.size() == 0, "R7 all beats delivered", 32'(exp_q.size()), 32'd0);
    chk_status(4, "R9 done state after playback");
    check(done && !busy, "R9 done flag", {30'd0, done, busy}, 32'd2);
    check(!m_tvalid, "R7 no beat after last", 32'(m_tvalid), 32'd0);
  endtask

  // stream sink with optional random stalls
  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m_tready = bp ? (lfsr[0] | lfsr[3]) & ~lfsr[7] : 1'b1;
    end
  end

  // monitor: compare each transferred beat
  always @(negedge clk) begin
    if (rst_n && m_tvalid && m_tready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected extra beat", m_tdata, 32'd0);
      end else begin
        logic [DATA_W-1:0] e;
        bit l;
        e = exp_q.pop_front();
        l = last_q.pop_front();
        check(m_tdata == e, "R3 record data order", m_tdata, e);
        check(m_tlast == l, "R7 tlast placement", 32'(m_tlast), 32'(l));
        if (l) mstate = 4;
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(status == 3'd0 && !busy && !done && !m_tvalid, "R1 reset state",
          {27'd0, status, busy, done}, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 1);

    // A: len 16, pre 4, ring wraps before the trigger
    arm_cmd(16, 4);
    step(0, 0, 1);
    chk_status(1, "R2 arm from idle");
    check(busy, "R9 busy when armed", 32'(busy), 32'd1);
    step(1, 1, 1);               // only 0 samples before: too early
    step(1, 0, 1);
    chk_status(1, "R5 early trigger ignored");
    for (int i = 0; i < 20; i++) step(1, 0, 1);
    step(1, 1, 0);               // disabled trigger
    step(1, 0, 1);
    chk_status(1, "R4 disabled trigger ignored");
    step(1, 1, 1);               // accepted
    step(1, 0, 1);
    chk_status(2, "R6 post-trigger state");
    arm_cmd(4, 1);               // ignored while in post-trigger
    step(0, 0, 1);
    chk_status(2, "R2 arm ignored during capture");
    for (int n = 0; n < 100 && mstate == 2; n++) step(1, 0, 1);
    for (int i = 0; i < 6; i++) step(1, 0, 1);   // R10 samples during readout
    drain();

    // B: full depth, pre 0, trigger at once, input gaps, stalls
    bp = 1;
    arm_cmd(DEPTH, 0);
    step(0, 0, 1);
    chk_status(1, "R2 arm from done");
    step(1, 1, 1);
    for (int n = 0; n < 400 && mstate == 2; n++) step((n % 3) != 0, 0, 1);
    step(0, 0, 1);
    chk_status(3, "R9 readout state");
    for (int i = 0; i < 10; i++) step(1, 0, 1);  // R10
    drain();

    // C: all pre-trigger (pre == len), stalls, arm during readout
    arm_cmd(8, 8);
    for (int i = 0; i < 8; i++) step(1, i == 3, 1);
    step(1, 1, 1);               // 8 written before: accepted, no post samples
    step(0, 0, 1);
    chk_status(3, "R6 pre equals len goes to readout");
    arm_cmd(5, 2);
    step(0, 0, 1);
    check(status != 3'd1, "R2 arm ignored during readout", 32'(status), 32'd3);
    drain();

    // D: single-entry ring
    bp = 0;
    arm_cmd(1, 0);
    step(1, 1, 1);
    step(1, 0, 1);
    drain();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule